// File: doc/BRIEF.md
# Routed Logic Gate Fabric

This block is a small event-routing fabric for trigger and gate signals. A shared bus carries two constant bits, the physical input bits and the registered results of four logic gates. Each gate input and each physical output picks one bus bit through a select register of its own. Any input or gate result can therefore reach any output or any gate input, and gates can be chained in any order.

There are two AND gates and two OR gates, each with four inputs. Each input has its own inversion bit and enable bit. A gate result is registered, so it appears on the bus one clock after the inputs that produced it. Physical outputs are plain multiplexors of the current bus. A simple write port loads the select and mask registers. The whole fabric runs on one clock, nominally 50 MHz.

Top module: `routed_gate_fabric`

## Requirements
- R1: While reset is held and on the first edge after it, every select, inversion and enable register is zero and every gate result is 0. As a result, all physical outputs read bus index 0 and are 0.
- R2: The bus index map is: 0 is constant 0, 1 is constant 1, 2 to 9 are phys_in[0] to phys_in[7], 10 and 11 are AND gates 0 and 1, and 12 and 13 are OR gates 0 and 1. A select value of 14 or 15 reads as 0.
- R3: phys_out[j] equals the bus bit named by its select register in the same cycle. A change on phys_in reaches an output that selects it with no clock edge in between.
- R4: A write with cfg_we high at a rising edge updates the register at cfg_addr at that edge. Before the edge, the old value stays in use. Addresses 0 to 3 hold the selects of phys_out[0..3] in cfg_wdata[3:0]. Addresses 4 and 5 configure AND gates 0 and 1, and addresses 6 and 7 configure OR gates 0 and 1. A gate word places the select for input k at bits [4k+3:4k], the inversion mask at [19:16] and the enable mask at [23:20], with bit k of each mask belonging to input k.
- R5: An AND gate registers the AND of (selected bit XOR inversion bit) over its enabled inputs. The result appears on the bus one clock later.
- R6: An OR gate registers the OR of (selected bit XOR inversion bit) over its enabled inputs. The result appears on the bus one clock later.
- R7: A gate with an all-zero enable mask registers 0, whatever its inputs and inversion mask.
- R8: A gate that selects another gate's result sees it one clock after that gate registered it. Each stage in a chain adds exactly one clock.
- R9: Writes to addresses 8 to 15, and any clock without a write, leave every configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| phys_in | input | 8 | Physical input bits, bus indices 2 to 9 |
| phys_out | output | 4 | Routed physical outputs |

## Verification
The hardest case to reach from the ports is a chained gate. Its input is never driven directly: it is only the previous cycle's value of another gate. The stimulus routes AND gate 0 into AND gate 1 and brings both results out on separate physical outputs. It then toggles one physical input and samples on the two following cycles, which shows one stage changing before the other. A second hard case is an enable mask of zero on an AND gate with every input high. A gate that wrongly used 1 as its empty result would show a 1 there, so the table walk includes that vector.

// File: rtl/fabric_pkg.sv
package fabric_pkg;
    localparam int N_PHYS     = 8;
    localparam int N_OUT      = 4;
    localparam int N_AND      = 2;
    localparam int N_OR       = 2;
    localparam int FAN_IN     = 4;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;

    localparam int N_GATE     = N_AND + N_OR;
    localparam int BUS_W      = 2 + N_PHYS + N_GATE;
    localparam int SEL_W      = $clog2(BUS_W);
    localparam int IDX_PHYS   = 2;
    localparam int IDX_GATE   = IDX_PHYS + N_PHYS;
    localparam int GATE_BASE  = N_OUT;
    localparam int N_REGS     = N_OUT + N_GATE;
    localparam int GATE_CFG_W = FAN_IN * SEL_W + 2 * FAN_IN;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic [FAN_IN-1:0] en;
        logic [FAN_IN-1:0] inv;
        sel_t [FAN_IN-1:0] sel;
    } gate_cfg_t;

    typedef struct packed {
        sel_t [N_OUT-1:0]       out_sel;
        gate_cfg_t [N_GATE-1:0] gate;
    } cfg_state_t;

    typedef struct packed {
        logic result;
    } gate_state_t;

    function automatic logic bus_pick(input logic [BUS_W-1:0] bus, input sel_t s);
        return (int'(s) < BUS_W) ? bus[s] : 1'b0;
    endfunction
endpackage

// File: rtl/fabric_cfg_regs.sv
module fabric_cfg_regs
    import fabric_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output sel_t [N_OUT-1:0]        out_sel,
    output gate_cfg_t [N_GATE-1:0]  gate_cfg
);
    cfg_state_t s_d, s_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:GATE_CFG_W];

    always_comb begin
        s_d = s_q;
        if (we) begin
            for (int j = 0; j < N_OUT; j++) begin
                if (int'(addr) == j) begin
                    s_d.out_sel[j] = wdata[SEL_W-1:0];
                end
            end
            for (int g = 0; g < N_GATE; g++) begin
                if (int'(addr) == GATE_BASE + g) begin
                    s_d.gate[g] = gate_cfg_t'(wdata[GATE_CFG_W-1:0]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_sel  = s_q.out_sel;
    assign gate_cfg = s_q.gate;
endmodule

// File: rtl/fabric_gate.sv
module fabric_gate
    import fabric_pkg::*;
#(
    parameter bit IS_OR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus,
    input  gate_cfg_t        cfg,
    output logic             result
);
    gate_state_t s_d, s_q;
    logic [FAN_IN-1:0] term;
    logic combined;

    always_comb begin
        for (int k = 0; k < FAN_IN; k++) begin
            term[k] = bus_pick(bus, cfg.sel[k]) ^ cfg.inv[k];
        end
    end

    generate
        if (IS_OR) begin : g_or
            assign combined = |(term & cfg.en);
        end else begin : g_and
            assign combined = (|cfg.en) & (&(term | ~cfg.en));
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.result = combined;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign result = s_q.result;
endmodule

// File: rtl/fabric_out_mux.sv
module fabric_out_mux
    import fabric_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    input  sel_t [N_OUT-1:0]  sel,
    output logic [N_OUT-1:0]  dout
);
    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            dout[j] = bus_pick(bus, sel[j]);
        end
    end
endmodule

// File: rtl/routed_gate_fabric.sv
module routed_gate_fabric
    import fabric_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_PHYS-1:0] phys_in,
    output logic [N_OUT-1:0]  phys_out
);
    sel_t [N_OUT-1:0]       cfg_out_sel;
    gate_cfg_t [N_GATE-1:0] cfg_gate;
    logic [N_GATE-1:0]      gate_q;
    logic [BUS_W-1:0]       bus;

    // gates sit above the inputs; indices 1 and 0 are the constants
    assign bus = {gate_q, phys_in, 1'b1, 1'b0};

    fabric_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .out_sel  (cfg_out_sel),
        .gate_cfg (cfg_gate)
    );

    generate
        for (genvar g = 0; g < N_GATE; g++) begin : g_gate
            fabric_gate #(
                .IS_OR (g >= N_AND)
            ) u_gate (
                .clk    (clk),
                .rst_n  (rst_n),
                .bus    (bus),
                .cfg    (cfg_gate[g]),
                .result (gate_q[g])
            );
        end
    endgenerate

    fabric_out_mux u_omux (
        .bus  (bus),
        .sel  (cfg_out_sel),
        .dout (phys_out)
    );
endmodule

// File: rtl/fabric_checker.sv
module fabric_checker
    import fabric_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      cfg_addr,
    input logic [DATA_W-1:0]      cfg_wdata,
    input logic [N_OUT-1:0]       phys_out,
    input sel_t [N_OUT-1:0]       cfg_out_sel,
    input gate_cfg_t [N_GATE-1:0] cfg_gate,
    input logic [N_GATE-1:0]      gate_q
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_q == '0 && cfg_out_sel == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cfg_out_sel) && $stable(cfg_gate)));

    p_unmapped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) >= N_REGS) |=> ($stable(cfg_out_sel) && $stable(cfg_gate)));

    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
            p_out_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && int'(cfg_addr) == j) |=> cfg_out_sel[j] == $past(cfg_wdata[SEL_W-1:0]));
            p_const_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_out_sel[j] == sel_t'(0)) |-> !phys_out[j]);
            p_const_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_out_sel[j] == sel_t'(1)) |-> phys_out[j]);
        end
        for (genvar g = 0; g < N_GATE; g++) begin : g_gate_chk
            p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_gate[g].en == '0) |=> !gate_q[g]);
        end
    endgenerate
endmodule

bind routed_gate_fabric fabric_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .phys_out    (phys_out),
    .cfg_out_sel (cfg_out_sel),
    .cfg_gate    (cfg_gate),
    .gate_q      (gate_q)
);

// File: tb/routed_gate_fabric_test.sv
module routed_gate_fabric_test;
    localparam int CLK_PERIOD = 20;
    localparam int N_VEC = 9;
    // {in[3:0], and_inv, and_en, or_inv, or_en, exp_and, exp_or}
    localparam logic [21:0] VEC [N_VEC] = '{
        {4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 1'b1, 1'b1},
        {4'b0111, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 1'b0, 1'b1},
        {4'b0111, 4'b1000, 4'b1111, 4'b0111, 4'b1111, 1'b1, 1'b0},
        {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0},
        {4'b0101, 4'b0000, 4'b0101, 4'b0000, 4'b1010, 1'b1, 1'b0},
        {4'b0101, 4'b1010, 4'b1010, 4'b0010, 4'b1010, 1'b1, 1'b1},
        {4'b1001, 4'b0001, 4'b0001, 4'b1000, 4'b1000, 1'b0, 1'b0},
        {4'b0110, 4'b0000, 4'b0110, 4'b0000, 4'b0001, 1'b1, 1'b0},
        {4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  phys_in = '0;
    logic [3:0]  phys_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    routed_gate_fabric uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .phys_in   (phys_in),
        .phys_out  (phys_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(phys_out, 4'b0000, "R1 outputs after reset");
        phys_in = 8'hFF;
        @(negedge clk); #1;
        check(phys_out, 4'b0000, "R1 reset selects read constant 0 (R2)");
        phys_in = '0;

        // route AND0 to out0 and OR0 to out1
        wr(0, 32'd10);
        wr(1, 32'd12);
        for (int v = 0; v < N_VEC; v++) begin
            wr(4, {8'h0, VEC[v][13:10], VEC[v][17:14], 16'h5432});
            wr(6, {8'h0, VEC[v][5:2], VEC[v][9:6], 16'h5432});
            phys_in = {4'b0, VEC[v][21:18]};
            @(negedge clk); #1;
            check(phys_out[0], VEC[v][1], $sformatf("R5 R7 AND vector %0d", v));
            check(phys_out[1], VEC[v][0], $sformatf("R6 R7 OR vector %0d", v));
        end

        // R4 write timing: old value before the edge, new after
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 32'd1;
        #1;
        check(phys_out[2], 1'b0, "R4 old select before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(phys_out[2], 1'b1, "R4 new select after edge, constant 1 (R2)");

        // R3 combinational path from phys_in[7]
        wr(3, 32'd9);
        #2; phys_in[7] = 1'b0; #1;
        check(phys_out[3], 1'b0, "R3 input low reaches output");
        phys_in[7] = 1'b1; #1;
        check(phys_out[3], 1'b1, "R3 input high reaches output without edge");

        // R2 out-of-range selects
        phys_in = 8'hFF;
        wr(3, 32'd15); #1;
        check(phys_out[3], 1'b0, "R2 select 15 reads 0");
        wr(3, 32'd14); #1;
        check(phys_out[3], 1'b0, "R2 select 14 reads 0");
        phys_in = 8'h01;
        wr(3, 32'd2); #1;
        check(phys_out[3], 1'b1, "R2 select 2 is phys_in[0]");

        // R8 chain AND0 -> AND1
        wr(4, {8'h0, 4'b0001, 4'b0000, 16'h0002});
        wr(5, {8'h0, 4'b0001, 4'b0000, 16'h000A});
        wr(0, 32'd10);
        wr(2, 32'd11);
        phys_in = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        check({phys_out[2], phys_out[0]}, 2'b00, "R8 chain idle");
        @(negedge clk);
        phys_in = 8'h01;
        @(negedge clk); #1;
        check({phys_out[2], phys_out[0]}, 2'b01, "R8 first stage after one clock");
        @(negedge clk); #1;
        check({phys_out[2], phys_out[0]}, 2'b11, "R8 second stage after two clocks");

        // R9 unmapped addresses leave configuration intact
        wr(1, 32'd1);
        wr(2, 32'd1);
        wr(3, 32'd1);
        for (int a = 8; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
        end
        repeat (2) @(negedge clk);
        #1;
        check(phys_out, 4'b1111, "R9 unmapped writes ignored");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule